// File: doc/BRIEF.md
# H-Bridge Protection and Fault Manager

This block sits between the synchronized protection comparators of a single H-bridge and the bridge control logic. It qualifies each comparator flag over time, then decides the response. A current over the limit first asks the PWM loop to cut its duty. If that condition lasts much longer, it also raises the fault output while the bridge keeps running. A short on any one of the bridge switches shuts the bridge down until power returns. Overtemperature stops the bridge until the die cools. Undervoltage stops the bridge and holds the rest of the controller in reset.

All delays are given in clock cycles, so the integrator turns the microsecond and millisecond figures into parameters from the known clock period. The fault output is an active-high pull-down enable for an open-drain pad, so the pin reads low while any fault is active. The sleep input comes from the command decoder. It forces the bridge off and clears the current-limit state.

Top module: `bridge_guard`

## Requirements
- R1: After `rst_n` is released with all flags low and `sleep_i` low, `duty_cut_o`, `bridge_off_o`, `logic_rst_o` and `fault_pd_o` are all 0.
- R2: While the bridge is driven, `duty_cut_o` becomes 1 right after the edge on which `ilim_i` has been sampled high on LIM_CYC consecutive edges. It stays 0 if `ilim_i` drops sooner.
- R3: When `ilim_i` has been sampled high on LIM_FAULT_CYC consecutive edges (LIM_FAULT_CYC > LIM_CYC), `fault_pd_o` becomes 1. `bridge_off_o` stays 0 and `duty_cut_o` stays 1.
- R4: The current-limit fault and the duty cut both clear right after the first edge on which `ilim_i` is sampled low or the bridge is off (sleep included). The count then restarts from zero.
- R5: When any one bit of `ocp_hs_i`/`ocp_ls_i` has been sampled high on OCP_CYC consecutive edges, `bridge_off_o` and `fault_pd_o` become 1. Both stay 1 after the flag drops, until `rst_n` or a qualified undervoltage.
- R6: Each switch has its own overcurrent count. A flag that drops before qualifying restarts that count from zero, and high samples on different switches never add up.
- R7: After `tsd_i` has been sampled high on TSD_CYC consecutive edges, `bridge_off_o` and `fault_pd_o` are 1. They return to 0 right after the first edge on which `tsd_i` is sampled low.
- R8: After `uv_i` has been sampled high on UV_CYC consecutive edges, `logic_rst_o`, `bridge_off_o` and `fault_pd_o` are 1. All other protection state, the overcurrent latch included, is cleared. All three outputs drop right after the first edge on which `uv_i` is sampled low.
- R9: `bridge_off_o` is 1 whenever `sleep_i` is 1, with no clock delay. Sleep alone does not assert `fault_pd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of known period |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sleep_i | input | 1 | Sleep command; bridge off, current-limit state cleared |
| ilim_i | input | 1 | Sense voltage above current-limit threshold |
| ocp_hs_i | input | N_LEG | Overcurrent flag per high-side switch |
| ocp_ls_i | input | N_LEG | Overcurrent flag per low-side switch |
| tsd_i | input | 1 | Die over temperature (hysteresis in the comparator) |
| uv_i | input | 1 | Supply below undervoltage threshold |
| duty_cut_o | output | 1 | Request to the PWM loop to reduce duty |
| bridge_off_o | output | 1 | All bridge switches off |
| logic_rst_o | output | 1 | Reset for the rest of the controller |
| fault_pd_o | output | 1 | Pull-down enable for the open-drain fault pin |

## Verification
Each timed response is due right after the edge that completes its count. Duty cut and the current-limit fault follow LIM_CYC and LIM_FAULT_CYC sampled highs. The overcurrent latch follows OCP_CYC, thermal shutdown TSD_CYC, and undervoltage UV_CYC. Every release takes effect one edge after the flag is sampled low, and sleep acts on `bridge_off_o` with no delay. The bench changes inputs on falling edges and reads outputs on the next falling edge. A behavioural model of the consecutive-sample counts is updated on each rising edge and compared every cycle, and directed checks sample exactly one cycle before and on the expiry of each window.

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int N_LEG         = 2,
  parameter int LIM_CYC       = 750,
  parameter int LIM_FAULT_CYC = 68_750_000,
  parameter int OCP_CYC       = 500,
  parameter int TSD_CYC       = 250,
  parameter int UV_CYC        = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             ilim_i,
  input  logic [N_LEG-1:0] ocp_hs_i,
  input  logic [N_LEG-1:0] ocp_ls_i,
  input  logic             tsd_i,
  input  logic             uv_i,
  output logic             duty_cut_o,
  output logic             bridge_off_o,
  output logic             logic_rst_o,
  output logic             fault_pd_o
);
  localparam int N_SW = 2 * N_LEG;
  localparam int LW = $clog2(LIM_FAULT_CYC + 1);
  localparam int OW = $clog2(OCP_CYC + 1);
  localparam int TW = $clog2(TSD_CYC + 1);
  localparam int UW = $clog2(UV_CYC + 1);

  logic [LW-1:0]   lim_cnt;
  logic [TW-1:0]   tsd_cnt;
  logic [UW-1:0]   uv_cnt;
  logic [N_SW-1:0] ocp_hit;
  logic            ocp_lat;
  logic            uv_act, tsd_act, lim_flt;
  logic [N_SW-1:0] ocp_flag;

  assign ocp_flag = {ocp_ls_i, ocp_hs_i};
  assign uv_act   = (uv_cnt == UW'(UV_CYC));
  assign tsd_act  = (tsd_cnt == TW'(TSD_CYC));
  assign lim_flt  = (lim_cnt == LW'(LIM_FAULT_CYC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          uv_cnt <= '0;
    else if (!uv_i)      uv_cnt <= '0;
    else if (!uv_act)    uv_cnt <= uv_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                uv_cnt_dummy_guard: tsd_cnt <= '0;
    else if (uv_act || !tsd_i) tsd_cnt <= '0;
    else if (!tsd_act)         tsd_cnt <= tsd_cnt + 1'b1;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    logic [OW-1:0] cnt;
    assign ocp_hit[i] = ocp_flag[i] && (cnt == OW'(OCP_CYC - 1));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      cnt <= '0;
      else if (uv_act || !ocp_flag[i]) cnt <= '0;
      else if (!ocp_hit[i])            cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ocp_lat <= 1'b0;
    else if (uv_act)   ocp_lat <= 1'b0;
    else if (|ocp_hit) ocp_lat <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     lim_cnt <= '0;
    else if (bridge_off_o || !ilim_i) lim_cnt <= '0;
    else if (!lim_flt)              lim_cnt <= lim_cnt + 1'b1;

  assign bridge_off_o = sleep_i | ocp_lat | tsd_act | uv_act;
  assign duty_cut_o   = (lim_cnt >= LW'(LIM_CYC));
  assign logic_rst_o  = uv_act;
  assign fault_pd_o   = lim_flt | ocp_lat | tsd_act | uv_act;
endmodule

module bridge_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ilim_i,
  input logic tsd_i,
  input logic sleep_i,
  input logic duty_cut_o,
  input logic bridge_off_o,
  input logic logic_rst_o,
  input logic fault_pd_o,
  input logic ocp_lat,
  input logic tsd_act
);
  AST_DUTY_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(duty_cut_o) |-> $past(ilim_i)); // R2
  AST_OCP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_lat && !logic_rst_o) |=> ocp_lat); // R5
  AST_OCP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_lat |-> (bridge_off_o && fault_pd_o)); // R5
  AST_TSD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !tsd_i |=> !tsd_act); // R7
  AST_UV_SHUTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |-> (bridge_off_o && fault_pd_o)); // R8
  AST_UV_CLEARS_OCP: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |=> !ocp_lat); // R8
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> bridge_off_o); // R9
  AST_SLEEP_CLEARS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !duty_cut_o); // R4
endmodule

bind bridge_guard bridge_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ilim_i(ilim_i), .tsd_i(tsd_i), .sleep_i(sleep_i),
  .duty_cut_o(duty_cut_o), .bridge_off_o(bridge_off_o), .logic_rst_o(logic_rst_o),
  .fault_pd_o(fault_pd_o), .ocp_lat(ocp_lat), .tsd_act(tsd_act)
);

// File: tb/tb_bridge_guard.sv
`timescale 1ns/1ps
module tb_bridge_guard;
  localparam int NL = 2, NS = 2 * NL;
  localparam int LIM = 6, LIMF = 40, OCP = 4, TSD = 3, UV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_i = 0, ilim_i = 0, tsd_i = 0, uv_i = 0;
  logic [NL-1:0] ocp_hs_i = '0, ocp_ls_i = '0;
  logic duty_cut_o, bridge_off_o, logic_rst_o, fault_pd_o;
  int n_chk = 0, n_err = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  bridge_guard #(.N_LEG(NL), .LIM_CYC(LIM), .LIM_FAULT_CYC(LIMF), .OCP_CYC(OCP),
                 .TSD_CYC(TSD), .UV_CYC(UV)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ilim_i(ilim_i),
    .ocp_hs_i(ocp_hs_i), .ocp_ls_i(ocp_ls_i), .tsd_i(tsd_i), .uv_i(uv_i),
    .duty_cut_o(duty_cut_o), .bridge_off_o(bridge_off_o),
    .logic_rst_o(logic_rst_o), .fault_pd_o(fault_pd_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference: consecutive high-sample runs per flag
  int r_lim, r_tsd, r_uv, r_ocp[NS];
  bit m_ocp, o_uv, o_tsd, o_off;
  logic [NS-1:0] fl;
  always @(posedge clk) begin
    if (!rst_n) begin
      r_lim = 0; r_tsd = 0; r_uv = 0; m_ocp = 0;
      for (int i = 0; i < NS; i++) r_ocp[i] = 0;
    end else begin
      o_uv  = (r_uv >= UV);
      o_tsd = (r_tsd >= TSD);
      o_off = sleep_i || m_ocp || o_tsd || o_uv;
      fl = {ocp_ls_i, ocp_hs_i};
      r_uv = uv_i ? ((r_uv < UV) ? r_uv + 1 : UV) : 0;
      if (o_uv) begin
        r_lim = 0; r_tsd = 0; m_ocp = 0;
        for (int i = 0; i < NS; i++) r_ocp[i] = 0;
      end else begin
        r_tsd = tsd_i ? ((r_tsd < TSD) ? r_tsd + 1 : TSD) : 0;
        for (int i = 0; i < NS; i++) begin
          if (fl[i]) begin
            r_ocp[i]++;
            if (r_ocp[i] >= OCP) m_ocp = 1;
          end else r_ocp[i] = 0;
        end
        r_lim = (ilim_i && !o_off) ? ((r_lim < LIMF) ? r_lim + 1 : LIMF) : 0;
      end
    end
  end

  always @(negedge clk) if (cmp_en) begin
    bit e_uv, e_tsd, e_lf;
    e_uv = (r_uv >= UV); e_tsd = (r_tsd >= TSD); e_lf = (r_lim >= LIMF);
    chk(duty_cut_o == (r_lim >= LIM), "R2 model duty_cut", duty_cut_o, int'(r_lim >= LIM));
    chk(fault_pd_o == (e_lf || m_ocp || e_tsd || e_uv), "R3 model fault_pd",
        fault_pd_o, int'(e_lf || m_ocp || e_tsd || e_uv));
    chk(bridge_off_o == (sleep_i || m_ocp || e_tsd || e_uv), "R5 model bridge_off",
        bridge_off_o, int'(sleep_i || m_ocp || e_tsd || e_uv));
    chk(logic_rst_o == e_uv, "R8 model logic_rst", logic_rst_o, int'(e_uv));
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    cmp_en = 1;
    chk({duty_cut_o, bridge_off_o, logic_rst_o, fault_pd_o} == 4'b0, "R1 reset state",
        {duty_cut_o, bridge_off_o, logic_rst_o, fault_pd_o}, 0);

    // R2 short burst then qualified limit
    ilim_i = 1; step(LIM - 1); ilim_i = 0;
    chk(duty_cut_o == 0, "R2 early drop", duty_cut_o, 0);
    step(1);
    ilim_i = 1; step(LIM - 1);
    chk(duty_cut_o == 0, "R2 one short", duty_cut_o, 0);
    step(1);
    chk(duty_cut_o == 1, "R2 qualified", duty_cut_o, 1);
    // R3 long limit
    step(LIMF - LIM - 1);
    chk(fault_pd_o == 0, "R3 one short", fault_pd_o, 0);
    step(1);
    chk(fault_pd_o == 1, "R3 fault", fault_pd_o, 1);
    chk(bridge_off_o == 0, "R3 bridge runs", bridge_off_o, 0);
    // R4 release by flag
    ilim_i = 0; step(1);
    chk(fault_pd_o == 0 && duty_cut_o == 0, "R4 flag release",
        {fault_pd_o, duty_cut_o}, 0);
    // R4 release by sleep, R9 immediate off
    ilim_i = 1; step(LIMF);
    chk(fault_pd_o == 1, "R3 fault again", fault_pd_o, 1);
    sleep_i = 1; #1;
    chk(bridge_off_o == 1, "R9 sleep immediate", bridge_off_o, 1);
    step(1);
    chk(fault_pd_o == 0 && duty_cut_o == 0, "R4 sleep release",
        {fault_pd_o, duty_cut_o}, 0);
    step(3);
    chk(fault_pd_o == 0, "R9 sleep no fault", fault_pd_o, 0);
    sleep_i = 0; ilim_i = 0; #1;
    chk(bridge_off_o == 0, "R9 wake", bridge_off_o, 0);
    step(1);

    // R6 separate counts, restart
    ocp_hs_i[0] = 1; step(OCP - 1);
    ocp_hs_i[0] = 0; ocp_ls_i[1] = 1; step(OCP - 1);
    ocp_ls_i[1] = 0; step(1);
    chk(bridge_off_o == 0, "R6 no sum across switches", bridge_off_o, 0);
    ocp_hs_i[1] = 1; step(OCP - 1); ocp_hs_i[1] = 0; step(1);
    ocp_hs_i[1] = 1; step(OCP - 1);
    chk(bridge_off_o == 0, "R6 restart", bridge_off_o, 0);
    ocp_hs_i[1] = 0; step(1);
    // R5 latch
    ocp_ls_i[0] = 1; step(OCP - 1);
    chk(bridge_off_o == 0, "R5 one short", bridge_off_o, 0);
    step(1);
    chk(bridge_off_o == 1 && fault_pd_o == 1, "R5 latched", {bridge_off_o, fault_pd_o}, 3);
    ocp_ls_i[0] = 0; step(6);
    chk(bridge_off_o == 1 && fault_pd_o == 1, "R5 held", {bridge_off_o, fault_pd_o}, 3);

    // R8 undervoltage clears the latch
    uv_i = 1; step(UV - 1);
    chk(logic_rst_o == 0, "R8 one short", logic_rst_o, 0);
    step(1);
    chk(logic_rst_o && bridge_off_o && fault_pd_o, "R8 uv active",
        {logic_rst_o, bridge_off_o, fault_pd_o}, 7);
    ilim_i = 1; tsd_i = 1; step(LIM + 2);
    chk(duty_cut_o == 0 && logic_rst_o == 1, "R8 others held", {duty_cut_o, logic_rst_o}, 1);
    ilim_i = 0; tsd_i = 0; uv_i = 0; step(1);
    chk({logic_rst_o, bridge_off_o, fault_pd_o} == 3'b0, "R8 release",
        {logic_rst_o, bridge_off_o, fault_pd_o}, 0);

    // R7 thermal
    tsd_i = 1; step(TSD - 1);
    chk(bridge_off_o == 0, "R7 one short", bridge_off_o, 0);
    step(1);
    chk(bridge_off_o && fault_pd_o, "R7 shutdown", {bridge_off_o, fault_pd_o}, 3);
    step(3); tsd_i = 0; step(1);
    chk(!bridge_off_o && !fault_pd_o, "R7 resume", {bridge_off_o, fault_pd_o}, 0);

    // mixed stimulus against the model
    for (int k = 0; k < 4000; k++) begin
      ilim_i  = ($urandom % 100) < 85 ? 1'b1 : 1'b0;
      sleep_i = ($urandom % 100) < 3;
      tsd_i   = ($urandom % 100) < 30;
      uv_i    = ($urandom % 100) < ((k % 500) < 20 ? 70 : 2);
      for (int j = 0; j < NL; j++) begin
        ocp_hs_i[j] = ($urandom % 100) < 40;
        ocp_ls_i[j] = ($urandom % 100) < 40;
      end
      step(1);
    end
    cmp_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule